// File: doc/BRIEF.md
# Folded Second-Order Recursive Filter

This block is a second-order IIR section in which every multiply and every add goes through one shared saturating adder and one shared two-stage constant multiplier. A free-running two-bit phase counter divides time into four-cycle periods. Each period takes one sample and updates the recursion state. It also computes one filtered output. The four products and four sums of a sample are spread over the four phases so that neither unit is ever asked for two things in the same cycle.

Partial results live in two small register files, each with one read and one write port. The state store is written only by the adder and is the only thing the multiplier reads. The product store is written only by the multiplier. The adder takes its first operand from the sample input, the multiplier result or the state store. It takes its second operand from the product store or from its own result register. The filter is meant to sit behind a sample source that presents one word per four clocks, with valid raised in the accepting phase.

Top module: `biquad_fold`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `out_data` is 0. The recursion state starts at zero, so the first output after reset equals the first accepted sample.
- R2: Phase 0 is the first cycle after reset is released, and the phase then steps 0,1,2,3,0 without stopping. `in_data` and `in_valid` are sampled only in phase 0. Their values in phases 1 to 3 have no effect on any output.
- R3: For a sample accepted in phase 0, `out_valid` is high in the phase-3 cycle of the same period, three cycles later, and carries that sample's output.
- R4: With all words in two's complement Q1.15 (value = word / 32768), the block computes w[n] = x[n] + 0.2·w[n-1] + 0.4·w[n-2] and y[n] = w[n] + 0.3·w[n-1] + 0.6·w[n-2]. The coefficient words are 6554 (0.2), 13107 (0.4), 9830 (0.3) and 19661 (0.6).
- R5: Each product is formed as the full 32-bit signed product, plus 16384, arithmetically shifted right by 15, then clamped to the 16-bit range.
- R6: Every addition clamps to [-32768, 32767] instead of wrapping. The grouping is fixed: s = 0.2·w[n-1] + 0.4·w[n-2] and then w[n] = x[n] + s. Likewise t = 0.3·w[n-1] + 0.6·w[n-2] and then y[n] = w[n] + t.
- R7: If `in_valid` is low in phase 0, a zero sample is used and the state still advances. `out_valid` stays low for that whole period.
- R8: `out_valid` is high only in phase 3 and is never high in two consecutive cycles.
- R9: `out_data` holds its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present (looked at in phase 0 only) |
| in_data | input | DATA_W | Input sample, Q1.15 |
| out_valid | output | 1 | One-cycle strobe for a new output sample |
| out_data | output | DATA_W | Output sample, Q1.15, registered |

## Verification
The hardest case to reach from the ports is clamping inside the recursion itself. Here a rounded feedback sum, or the sum of the sample and the feedback, hits a rail while the stored state still comes back round the loop. The stimulus gets there with long runs of full-scale positive and negative steps: a DC gain of 2.5 drives w to the rails within a few periods, and the clamped state then feeds the next products. Small-amplitude runs exercise rounding of tiny products. Random gaps in the phase-0 strobe test zero insertion, and garbage on the input pins in phases 1 to 3 tests that those phases are ignored.

// File: rtl/biquad_fold_pkg.sv
package biquad_fold_pkg;

  // Four time slots per sample; the schedule below is built for exactly this.
  localparam int unsigned SLOTS = 4;
  localparam int unsigned PH_W  = $clog2(SLOTS);
  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_ACCEPT = phase_t'(0);
  localparam phase_t PH_FFSUM  = phase_t'(1);
  localparam phase_t PH_OUTPUT = phase_t'(2);
  localparam phase_t PH_FBSUM  = phase_t'(3);

  // Store depths fixed by the schedule: the state store ping-pongs,
  // and the product store holds one feedback and one feedforward term.
  localparam int unsigned ST_DEPTH = 2;
  localparam int unsigned PR_DEPTH = 2;
  localparam int unsigned ST_AW    = $clog2(ST_DEPTH);
  localparam int unsigned PR_AW    = $clog2(PR_DEPTH);
  typedef logic [ST_AW-1:0] st_addr_t;
  typedef logic [PR_AW-1:0] pr_addr_t;

  typedef enum logic [1:0] {
    OPA_SAMPLE = 2'd0,
    OPA_PROD   = 2'd1,
    OPA_STATE  = 2'd2
  } opa_sel_e;

  typedef enum logic {
    OPB_ACC  = 1'b0,
    OPB_PMEM = 1'b1
  } opb_sel_e;

  typedef struct packed {
    opa_sel_e a_sel;
    opb_sel_e b_sel;
    phase_t   coef_sel;
    logic     take;
    logic     st_we;
    st_addr_t st_waddr;
    st_addr_t st_raddr;
    logic     pr_we;
    pr_addr_t pr_waddr;
    pr_addr_t pr_raddr;
    logic     out_load;
  } fold_ctl_t;

endpackage

// File: rtl/fold_ctrl.sv
module fold_ctrl
  import biquad_fold_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  output phase_t    phase,
  output fold_ctl_t ctl
);

  phase_t ph_q;
  logic   par_q;   // which state word holds the newest w
  logic   tag_q;   // the sample of this period was real

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_ACCEPT;
      par_q <= 1'b0;
      tag_q <= 1'b0;
    end else begin
      ph_q <= phase_t'(ph_q + 1'b1);
      if (ph_q == PH_ACCEPT) begin
        par_q <= ~par_q;
        tag_q <= in_valid;
      end
    end
  end

  // Multiplier slot order by phase: 0.6*w_old, 0.2*w, 0.4*w, 0.3*w.
  // Product store: slot 0 written in phase 0, read in phase 3;
  //                slot 1 written in phase 2, read in phase 1.
  always_comb begin
    ctl          = '0;
    ctl.coef_sel = ph_q;
    ctl.st_raddr = st_addr_t'(par_q);
    ctl.st_waddr = st_addr_t'(~par_q);
    ctl.pr_we    = ~ph_q[0];
    ctl.pr_waddr = pr_addr_t'(ph_q[1]);
    ctl.pr_raddr = pr_addr_t'(~ph_q[1]);
    unique case (ph_q)
      PH_ACCEPT: begin
        ctl.a_sel = OPA_SAMPLE;
        ctl.b_sel = OPB_ACC;
        ctl.take  = in_valid;
        ctl.st_we = 1'b1;
      end
      PH_FFSUM: begin
        ctl.a_sel = OPA_PROD;
        ctl.b_sel = OPB_PMEM;
      end
      PH_OUTPUT: begin
        ctl.a_sel    = OPA_STATE;
        ctl.b_sel    = OPB_ACC;
        ctl.out_load = tag_q;
      end
      default: begin
        ctl.a_sel = OPA_PROD;
        ctl.b_sel = OPB_PMEM;
      end
    endcase
  end

  assign phase = ph_q;

  // R2: the phase advances by one every cycle out of reset
  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ph_q == phase_t'($past(ph_q) + 1'b1)));

endmodule

// File: rtl/fold_regfile.sv
module fold_regfile #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fold_cmul.sv
module fold_cmul
  import biquad_fold_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned FRAC = 15,
  parameter logic signed [W-1:0] C_SLOT0 = 16'sd19661,
  parameter logic signed [W-1:0] C_SLOT1 = 16'sd6554,
  parameter logic signed [W-1:0] C_SLOT2 = 16'sd13107,
  parameter logic signed [W-1:0] C_SLOT3 = 16'sd9830
) (
  input  logic                clk,
  input  logic                rst,
  input  phase_t              sel,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);

  localparam int unsigned PW = 2 * W;
  localparam logic signed [PW:0] HALF = (PW+1)'(1) << (FRAC - 1);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0]  coef;
  logic signed [PW-1:0] prod_q;
  logic signed [PW:0]   biased;
  logic signed [PW:0]   shifted;
  logic signed [W-1:0]  clamped;
  logic signed [W-1:0]  res_q;

  always_comb begin
    unique case (sel)
      2'd0:    coef = C_SLOT0;
      2'd1:    coef = C_SLOT1;
      2'd2:    coef = C_SLOT2;
      default: coef = C_SLOT3;
    endcase
  end

  always_comb begin
    biased  = $signed({prod_q[PW-1], prod_q}) + HALF;
    shifted = biased >>> FRAC;
    if (shifted[PW:W-1] == {(PW-W+2){shifted[PW]}}) clamped = shifted[W-1:0];
    else if (shifted[PW])                            clamped = MINV;
    else                                             clamped = MAXV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      res_q  <= '0;
    end else begin
      prod_q <= din * coef;
      res_q  <= clamped;
    end
  end

  assign dout = res_q;

  // R5: rounding a non-negative product never yields a negative word
  a_r5_sign_kept: assert property (@(posedge clk) disable iff (rst)
    !prod_q[PW-1] |=> !res_q[W-1]);

endmodule

// File: rtl/fold_add.sv
module fold_add #(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] sum,
  output logic signed [W-1:0] acc
);

  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0]   ext;
  logic signed [W-1:0] acc_q;

  always_comb begin
    ext = {a[W-1], a} + {b[W-1], b};
    if (ext[W] != ext[W-1]) sum = ext[W] ? MINV : MAXV;
    else                    sum = ext[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum;
  end

  assign acc = acc_q;

  // R6: like-signed operands never produce an opposite-signed sum
  a_r6_no_wrap_pos: assert property (@(posedge clk) disable iff (rst)
    (!a[W-1] && !b[W-1]) |-> !sum[W-1]);
  a_r6_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
    (a[W-1] && b[W-1]) |-> sum[W-1]);

endmodule

// File: rtl/biquad_fold.sv
module biquad_fold
  import biquad_fold_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 15,
  parameter logic signed [DATA_W-1:0] FB1 = 16'sd6554,   // 0.2
  parameter logic signed [DATA_W-1:0] FB2 = 16'sd13107,  // 0.4
  parameter logic signed [DATA_W-1:0] FF1 = 16'sd9830,   // 0.3
  parameter logic signed [DATA_W-1:0] FF2 = 16'sd19661   // 0.6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  phase_t    phase;
  fold_ctl_t ctl;

  logic signed [DATA_W-1:0] opa, opb, sum, acc;
  logic signed [DATA_W-1:0] st_rdata, pr_rdata, prod;
  logic [DATA_W-1:0]        st_rdata_u, pr_rdata_u;
  logic [DATA_W-1:0]        out_q;
  logic                     vld_q;

  fold_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .phase    (phase),
    .ctl      (ctl)
  );

  always_comb begin
    unique case (ctl.a_sel)
      OPA_SAMPLE: opa = ctl.take ? $signed(in_data) : '0;
      OPA_PROD:   opa = prod;
      OPA_STATE:  opa = st_rdata;
      default:    opa = '0;
    endcase
    opb = (ctl.b_sel == OPB_PMEM) ? pr_rdata : acc;
  end

  fold_add #(.W(DATA_W)) u_add (
    .clk (clk),
    .rst (rst),
    .a   (opa),
    .b   (opb),
    .sum (sum),
    .acc (acc)
  );

  fold_regfile #(.W(DATA_W), .DEPTH(ST_DEPTH)) u_state_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl.st_we),
    .waddr (ctl.st_waddr),
    .wdata (sum),
    .raddr (ctl.st_raddr),
    .rdata (st_rdata_u)
  );
  assign st_rdata = $signed(st_rdata_u);

  fold_cmul #(
    .W       (DATA_W),
    .FRAC    (FRAC_W),
    .C_SLOT0 (FF2),
    .C_SLOT1 (FB1),
    .C_SLOT2 (FB2),
    .C_SLOT3 (FF1)
  ) u_cmul (
    .clk  (clk),
    .rst  (rst),
    .sel  (ctl.coef_sel),
    .din  (st_rdata),
    .dout (prod)
  );

  fold_regfile #(.W(DATA_W), .DEPTH(PR_DEPTH)) u_prod_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl.pr_we),
    .waddr (ctl.pr_waddr),
    .wdata (prod),
    .raddr (ctl.pr_raddr),
    .rdata (pr_rdata_u)
  );
  assign pr_rdata = $signed(pr_rdata_u);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ctl.out_load;
      if (ctl.out_load) out_q <= sum;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = out_q;

  // R8: the strobe sits in phase 3 and lasts one cycle
  a_r8_strobe_slot: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (phase == PH_FBSUM));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);
  // R9: output word holds between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> $stable(out_q));

endmodule

// File: tb/tb_biquad_fold.sv
module tb_biquad_fold;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  always #2 clk = ~clk;   // 250 MHz

  biquad_fold dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  longint w1 = 0, w2 = 0, last_y = 0;

  function automatic longint sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint mulr(longint c, longint x);
    longint p;
    p = c * x;
    p = (p + 16384) >>> 15;
    return sat16(p);
  endfunction

  function automatic longint model_step(longint x);
    longint s, t, w, y;
    s = sat16(mulr(6554, w1) + mulr(13107, w2));
    w = sat16(x + s);
    t = sat16(mulr(9830, w1) + mulr(19661, w2));
    y = sat16(w + t);
    w2 = w1;
    w1 = w;
    return y;
  endfunction

  task automatic check(string tag, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at the falling edge inside a reset cycle or a phase-0 cycle.
  task automatic run_period(bit v, longint x, string tag);
    longint y;
    rst      = 1'b0;
    in_valid = v;
    in_data  = W'(x);
    y = model_step(v ? x : 0);
    // phase 1: garbage on the pins must be ignored (R2)
    @(negedge clk);
    in_valid = 1'($urandom);
    in_data  = W'($urandom);
    check("R8 no strobe in phase 1", out_valid == 1'b0, longint'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'($urandom);
    in_data  = W'($urandom);
    check("R8 no strobe in phase 2", out_valid == 1'b0, longint'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'($urandom);
    in_data  = W'($urandom);
    if (v) begin
      check("R3 strobe in phase 3", out_valid == 1'b1, longint'(out_valid), 1);
      check(tag, longint'($signed(out_data)) == y, longint'($signed(out_data)), y);
      last_y = y;
    end else begin
      check("R7 no strobe for absent sample", out_valid == 1'b0, longint'(out_valid), 0);
      check("R9 output held", longint'($signed(out_data)) == last_y,
            longint'($signed(out_data)), last_y);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst      = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", out_valid == 1'b0, longint'(out_valid), 0);
    check("R1 reset out_data", out_data == '0, longint'($signed(out_data)), 0);
    w1 = 0; w2 = 0; last_y = 0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    do_reset();

    // impulse (R4); first output equals the sample (R1)
    run_period(1, 32767, "R1 first output");
    for (int i = 0; i < 20; i++) run_period(1, 0, "R4 impulse tail");

    // positive full-scale step drives the recursion into clamping (R6)
    do_reset();
    for (int i = 0; i < 30; i++) run_period(1, 32767, "R6 positive step");

    // negative full-scale step
    do_reset();
    for (int i = 0; i < 30; i++) run_period(1, -32768, "R6 negative step");

    // moderate step, no clamping
    do_reset();
    for (int i = 0; i < 30; i++) run_period(1, 4000, "R4 step");

    // tiny values stress product rounding (R5)
    do_reset();
    for (int i = 0; i < 60; i++)
      run_period(1, longint'($urandom_range(16)) - 8, "R5 small amplitude");

    // gaps: absent samples become zeros (R7)
    do_reset();
    for (int i = 0; i < 80; i++)
      run_period(($urandom_range(3) != 0), longint'($signed(W'($urandom))), "R7 gapped stream");

    // long random stream with occasional gaps (R2 garbage in other phases)
    do_reset();
    for (int i = 0; i < 1500; i++)
      run_period(($urandom_range(15) != 0), longint'($signed(W'($urandom))), "R2 random stream");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule